// File: doc/BRIEF.md
# Power-Up and Oscillator Start-Up Reset Sequencer

This block produces the internal reset for a small microcontroller core. It watches a digital supply-good flag and an active-low external clear input, and it keeps the core in reset until two waits have finished, one after the other. The first wait is a fixed power-up delay, measured by counting pulses of a slow free-running timebase. The second wait is an oscillator settling delay, measured by counting pulses of the main oscillator. The analog supply detector and the oscillator circuit are outside the block. Both reach it only as single-cycle strobes and levels that are synchronous to the system clock.

Only crystal-type oscillator modes need the settling count. When the oscillator is RC or an external clock, the sequencer goes straight to run once the power-up delay is over. A reset raised only by the external clear pin, while the supply stayed good, skips the power-up delay. The oscillator count still runs in crystal modes. A loss of supply at any moment brings back the full sequence. Both delays are parameters: `PWRUP_TICKS` (72 by default, for a 1 ms timebase) and `OST_CYCLES` (1024 by default).

Top module: `rst_seq_top`

## Requirements
- R1: While the synchronous reset `rst` is high, `core_rst_o` is 1 on the next clock edge, and a power-up delay is pending when `rst` falls.
- R2: While `supply_ok_i` is 0, `core_rst_o` is 1 from the next clock edge, whatever state the sequencer was in before.
- R3: With a power-up delay pending and both `supply_ok_i` and `clear_n_i` high, reset stays asserted until `PWRUP_TICKS` pulses of `timebase_tick_i` have been seen in the power-up wait. With no timebase pulses, reset is held indefinitely.
- R4: In the crystal modes (`osc_mode_i` = 2'b00, 2'b01, 2'b10), `OST_CYCLES` pulses of `osc_pulse_i` are counted in the oscillator wait before reset is released.
- R5: In mode 2'b11 (RC or external clock), no oscillator count is made. Reset is released on the clock edge that completes the power-up delay, or on the edge after entry when no delay is pending.
- R6: `clear_n_i` = 0 forces `core_rst_o` to 1 from the next clock edge. Reset is never released on an edge where `supply_ok_i` or `clear_n_i` was low.
- R7: After a clear that was not preceded by a supply loss, the power-up delay is skipped. Crystal modes still run the full oscillator count.
- R8: A pending power-up delay is cleared only when the power-up wait completes. A clear pulse during that wait does not cancel it, and the wait restarts from zero after the release. The oscillator wait never returns to the power-up wait.
- R9: `core_rst_o` is 0 only in the run state, and it stays 0 while `supply_ok_i` and `clear_n_i` remain high.
- R10: Timebase pulses outside the power-up wait, and oscillator pulses outside the oscillator wait, have no effect. Each count restarts from zero whenever its wait is entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply-good level, 1 when above threshold |
| clear_n_i | input | 1 | External clear, active low |
| osc_mode_i | input | 2 | Oscillator mode: 00/01/10 crystal, 11 RC or external clock |
| timebase_tick_i | input | 1 | Single-cycle pulse from the slow power-up timebase |
| osc_pulse_i | input | 1 | Single-cycle pulse per main-oscillator cycle |
| core_rst_o | output | 1 | Registered internal reset, active high |

## Verification
The bench builds the sequencer with `PWRUP_TICKS` = 6 and `OST_CYCLES` = 10. At these values both waits finish in a few dozen cycles, so one run can cover every mode, a clear pulse in the middle of each wait, supply loss from run and a held-off timebase. Timebase pulses arrive every third cycle and oscillator pulses every second cycle. Their phases therefore drift against the state transitions, which exercises count completion in the entry cycle and in later cycles.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE_RESET   = 2'd0,
    ST_POWERUP_WAIT = 2'd1,
    ST_OSC_WAIT     = 2'd2,
    ST_RUN          = 2'd3
  } seq_state_e;

  // Oscillator mode code that needs no settling count (RC or external clock)
  localparam logic [1:0] MODE_NO_SETTLE = 2'b11;

  function automatic logic needs_settle(input logic [1:0] mode);
    return mode != MODE_NO_SETTLE;
  endfunction

endpackage

// File: rtl/rst_seq_evcnt.sv
// Counts single-cycle events while armed; flags the event that reaches LIMIT.
module rst_seq_evcnt #(
  parameter int unsigned LIMIT = 72
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic ev_i,
  output logic done_o
);
  localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic         at_last;

  assign at_last = (cnt_q == LAST);
  assign done_o  = arm_i & ev_i & at_last;

  always_ff @(posedge clk) begin
    if (rst || !arm_i) begin
      cnt_q <= '0;
    end else if (ev_i) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rst_seq_cause.sv
// Remembers whether a supply event still owes a power-up delay.
module rst_seq_cause (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic clear_n_i,
  input  logic pw_done_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (rst || !supply_ok_i) begin
      pend_o <= 1'b1;
    end else if (pw_done_i && clear_n_i) begin
      pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok_i,
  input  logic       clear_n_i,
  input  logic       settle_i,
  input  logic       pend_i,
  input  logic       pw_done_i,
  input  logic       os_done_i,
  output seq_state_e st_q,
  output logic       core_rst_o
);
  seq_state_e st_d;

  always_comb begin
    st_d = st_q;
    if (!supply_ok_i || !clear_n_i) begin
      st_d = ST_IDLE_RESET;
    end else begin
      unique case (st_q)
        ST_IDLE_RESET: begin
          if (pend_i)        st_d = ST_POWERUP_WAIT;
          else if (settle_i) st_d = ST_OSC_WAIT;
          else               st_d = ST_RUN;
        end
        ST_POWERUP_WAIT: begin
          if (pw_done_i) st_d = settle_i ? ST_OSC_WAIT : ST_RUN;
        end
        ST_OSC_WAIT: begin
          if (os_done_i) st_d = ST_RUN;
        end
        ST_RUN: st_d = ST_RUN;
        default: st_d = ST_IDLE_RESET;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE_RESET;
      core_rst_o <= 1'b1;
    end else begin
      st_q       <= st_d;
      core_rst_o <= (st_d != ST_RUN);
    end
  end
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int unsigned PWRUP_TICKS = 72,
  parameter int unsigned OST_CYCLES  = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok_i,
  input  logic       clear_n_i,
  input  logic [1:0] osc_mode_i,
  input  logic       timebase_tick_i,
  input  logic       osc_pulse_i,
  output logic       core_rst_o
);
  seq_state_e st_q;
  logic       settle;
  logic       pend;
  logic       pw_done;
  logic       os_done;

  assign settle = needs_settle(osc_mode_i);

  rst_seq_evcnt #(.LIMIT(PWRUP_TICKS)) pw_cnt_i (
    .clk    (clk),
    .rst    (rst),
    .arm_i  (st_q == ST_POWERUP_WAIT),
    .ev_i   (timebase_tick_i),
    .done_o (pw_done)
  );

  rst_seq_evcnt #(.LIMIT(OST_CYCLES)) os_cnt_i (
    .clk    (clk),
    .rst    (rst),
    .arm_i  (st_q == ST_OSC_WAIT),
    .ev_i   (osc_pulse_i),
    .done_o (os_done)
  );

  rst_seq_cause cause_i (
    .clk         (clk),
    .rst         (rst),
    .supply_ok_i (supply_ok_i),
    .clear_n_i   (clear_n_i),
    .pw_done_i   (pw_done),
    .pend_o      (pend)
  );

  rst_seq_fsm fsm_i (
    .clk         (clk),
    .rst         (rst),
    .supply_ok_i (supply_ok_i),
    .clear_n_i   (clear_n_i),
    .settle_i    (settle),
    .pend_i      (pend),
    .pw_done_i   (pw_done),
    .os_done_i   (os_done),
    .st_q        (st_q),
    .core_rst_o  (core_rst_o)
  );
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk
  import rst_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       supply_ok_i,
  input logic       clear_n_i,
  input logic       core_rst_o,
  input seq_state_e st_q
);
  p_supply_loss_r2: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> core_rst_o);

  p_clear_forces_r6: assert property (@(posedge clk) disable iff (rst)
    !clear_n_i |=> core_rst_o);

  p_release_inputs_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst_o) |-> ($past(supply_ok_i) && $past(clear_n_i)));

  p_release_in_run_r9: assert property (@(posedge clk) disable iff (rst)
    !core_rst_o |-> (st_q == ST_RUN));

  p_run_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && supply_ok_i && clear_n_i) |=> !core_rst_o);

  p_no_back_to_pw_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OSC_WAIT) |=> (st_q != ST_POWERUP_WAIT));
endmodule

bind rst_seq_top rst_seq_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .supply_ok_i (supply_ok_i),
  .clear_n_i   (clear_n_i),
  .core_rst_o  (core_rst_o),
  .st_q        (st_q)
);

// File: tb/rst_seq_top_tb_top.sv
`timescale 1ns/1ps
module rst_seq_top_tb_top;
  localparam int PW = 6;
  localparam int OS = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_ok = 1'b0;
  logic       clear_n = 1'b1;
  logic [1:0] mode = 2'b01;
  logic       tick = 1'b0;
  logic       osc = 1'b0;
  logic       core_rst;

  bit tick_en = 1'b0;
  bit osc_en  = 1'b0;
  int cyc = 0;
  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";

  // behavioural reference: 0 idle, 1 power-up wait, 2 osc wait, 3 run
  int  m_st = 0, m_tc = 0, m_oc = 0;
  bit  m_pend = 1'b1;
  bit  m_rst = 1'b1;

  always #2 clk = ~clk;

  rst_seq_top #(.PWRUP_TICKS(PW), .OST_CYCLES(OS)) dut_i (
    .clk             (clk),
    .rst             (rst),
    .supply_ok_i     (supply_ok),
    .clear_n_i       (clear_n),
    .osc_mode_i      (mode),
    .timebase_tick_i (tick),
    .osc_pulse_i     (osc),
    .core_rst_o      (core_rst)
  );

  always @(posedge clk) begin
    int nx;
    bit xtal;
    bit pw_fin;
    cyc++;
    xtal = (mode != 2'b11);
    if (rst) begin
      m_st = 0; m_tc = 0; m_oc = 0; m_pend = 1'b1; m_rst = 1'b1;
    end else begin
      pw_fin = (m_st == 1) && tick && (m_tc == PW - 1);
      nx = m_st;
      if (!supply_ok || !clear_n) nx = 0;
      else if (m_st == 0) nx = m_pend ? 1 : (xtal ? 2 : 3);
      else if (m_st == 1 && pw_fin) nx = xtal ? 2 : 3;
      else if (m_st == 2 && osc && m_oc == OS - 1) nx = 3;
      if (!supply_ok) m_pend = 1'b1;
      else if (pw_fin && clear_n) m_pend = 1'b0;
      m_tc = (m_st == 1) ? (tick ? ((m_tc == PW - 1) ? 0 : m_tc + 1) : m_tc) : 0;
      m_oc = (m_st == 2) ? (osc ? ((m_oc == OS - 1) ? 0 : m_oc + 1) : m_oc) : 0;
      m_st = nx;
      m_rst = (nx != 3);
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: run did not complete (%s)", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // per-cycle comparison and pulse generation, away from the active edge
  always @(negedge clk) begin
    vectors++;
    if (core_rst !== m_rst) begin
      fails++;
      $display("FAIL %s cycle %0d: core_rst_o actual %b expected %b", cur_req, cyc, core_rst, m_rst);
    end
    tick <= tick_en && (cyc % 3 == 0);
    osc  <= osc_en && (cyc % 2 == 1);
  end

  task automatic chk(input logic actual, input logic expected, input string req);
    vectors++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: core_rst_o actual %b expected %b", req, actual, expected);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_release(input string req);
    for (int i = 0; i < 400 && core_rst; i++) @(negedge clk);
    chk(core_rst, 1'b0, req);
  endtask

  initial begin
    // R1: reset state
    cycles(3);
    chk(core_rst, 1'b1, "R1");
    rst = 1'b0;
    cycles(2);
    chk(core_rst, 1'b1, "R1 R2 supply low");

    // R3: no timebase pulses, reset held
    cur_req = "R3";
    supply_ok = 1'b1; mode = 2'b00;
    cycles(30);
    chk(core_rst, 1'b1, "R3 no ticks");
    // R3/R4 crystal mode 00, R10 osc pulses during power-up wait ignored
    cur_req = "R4 R10";
    tick_en = 1'b1; osc_en = 1'b1;
    wait_release("R4 mode 00");
    cycles(20);
    chk(core_rst, 1'b0, "R9 run sticky");

    // R6/R7: clear in crystal mode 01 skips power-up, still counts osc
    cur_req = "R7";
    mode = 2'b01;
    clear_n = 1'b0;
    cycles(3);
    chk(core_rst, 1'b1, "R6 clear");
    clear_n = 1'b1;
    cycles(4);
    chk(core_rst, 1'b1, "R7 osc count still runs");
    wait_release("R7 mode 01");

    // R5/R7: clear in RC mode releases right away
    cur_req = "R5";
    mode = 2'b11;
    clear_n = 1'b0;
    cycles(2);
    clear_n = 1'b1;
    cycles(1);
    chk(core_rst, 1'b0, "R5 R7 immediate release");

    // R2/R8: supply loss from run, clear pulse in power-up wait keeps it pending
    cur_req = "R8";
    supply_ok = 1'b0;
    cycles(2);
    chk(core_rst, 1'b1, "R2 supply loss");
    supply_ok = 1'b1;
    cycles(5);
    clear_n = 1'b0;
    cycles(2);
    clear_n = 1'b1;
    cycles(3);
    chk(core_rst, 1'b1, "R8 power-up restarts");
    wait_release("R5 R8 mode 11");

    // R4: mode 10, clear during osc wait restarts the count
    cur_req = "R4";
    mode = 2'b10;
    supply_ok = 1'b0;
    cycles(1);
    supply_ok = 1'b1;
    for (int i = 0; i < 200 && core_rst; i++) begin
      @(negedge clk);
      if (i == 25) begin
        clear_n = 1'b0;
        @(negedge clk);
        clear_n = 1'b1;
      end
    end
    chk(core_rst, 1'b0, "R4 mode 10");

    // R10: pulses in run and ticks during osc wait have no effect
    cur_req = "R10";
    cycles(15);
    chk(core_rst, 1'b0, "R10 run ignores pulses");
    osc_en = 1'b0;
    clear_n = 1'b0;
    cycles(1);
    clear_n = 1'b1;
    cycles(40);
    chk(core_rst, 1'b1, "R10 ticks do not advance osc wait");
    osc_en = 1'b1;
    wait_release("R10 osc wait resumes");

    cycles(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule